// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a 24-bit periodic timer reached through a small word-addressed register port. Software sets a reload value and turns the timer on. The counter then steps down by one on each tick. When a decrement brings it to zero, the block sets a sticky expiry flag and, if interrupts are enabled, drives a single-cycle interrupt pulse. The count stays at zero for one tick, then reloads. The period is therefore reload+1 ticks.

Ticks come from one of two sources, selected by a control bit. In one setting every core clock is a tick. In the other, a tick happens only on cycles where an external reference strobe is high. A write to the current-value register zeroes the count. A reload value of zero makes the timer stop at its next expiry, and the enable bit keeps its value. A read-only calibration word completes the register set.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word, reload value and current count all read as zero, and no interrupt pulse is driven.
- R2: Control register (offset 0x0) writes keep only bits 2:0: bit 0 is enable, bit 1 is interrupt enable, and bit 2 is the source select (1 = core clock, 0 = reference strobe). All other bits read back as zero, except bit 16.
- R3: The reload register (offset 0x4) stores only the low 24 bits of the written data, and reads return that 24-bit value zero-extended.
- R4: A write that changes enable from 0 to 1 zeroes the count. The first following tick loads the reload value, and counting down continues from there.
- R5: When the count is zero, the next tick loads the reload value. After a decrement reaches zero, the count therefore reads zero for one tick before reloading.
- R6: When the enable bit is set and the timer is not halted, a tick occurs on every clock with source select 1. With source select 0, a tick occurs only on clocks where the reference strobe is high.
- R7: A decrement from 1 to 0 sets the expiry flag. If interrupt enable is set, the same decrement also raises the interrupt output for exactly one clock.
- R8: Reading the control register returns the expiry flag in bit 16 and clears the flag. If an expiry happens in the same cycle as the read, the flag stays set.
- R9: The count holds its value while the enable bit is clear. It also holds during any clock in which a register write is accepted.
- R10: Any write to the current-value register (offset 0x8) sets the count to zero and clears the expiry flag, without setting the flag and without raising an interrupt. The next tick reloads the count, unless the reload value is zero.
- R11: The calibration register (offset 0xC) always reads 10000 decimal, and writes to it are ignored.
- R12: If the count expires while the reload value is zero, or the count is zeroed by a write while the reload value is zero, counting stops and the enable bit stays set. Only a new 0-to-1 enable transition restarts the counter.
- R13: Any other address, including unaligned addresses and offsets at 0x10 and above, reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_strobe | input | 1 | External reference tick strobe, sampled on each clock |
| bus_valid | input | 1 | Register access valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, for the current address |
| irq_pulse | output | 1 | One-clock interrupt pulse on expiry |

## Verification
The counter is driven mostly from the reference strobe, so the bench decides the exact number of ticks. Idle stretches with the strobe low show that no-tick cycles are ignored. A short run with the core clock as the source shows that every cycle counts. The sequences cover several kinds of zero count: reaching zero by decrement (flag and pulse), zeroing by write (no flag), zeroing on enable, and expiry with a zero reload (halt with the enable bit kept). Together these separate the rest-then-reload rule from an immediate reload. The bench also toggles interrupt enable between expiries to separate setting the flag from raising the pulse.

// File: rtl/tt_pkg.sv
// Shared constants and types for the tick timer.
// Assumes word-aligned register offsets and a 32-bit data path.
package tt_pkg;
    localparam int DATA_W      = 32;
    localparam int FLAG_BIT    = 16;
    localparam int CTRL_BITS   = 3;
    localparam int NUM_REGS    = 4;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_CALIB  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic clk_src;   // 1: every core clock ticks
        logic irq_en;    // pulse on expiry
        logic run_en;    // counter enabled
    } ctrl_t;
endpackage

// File: rtl/tt_decode.sv
// Address decoder: turns one bus access into a register select and per-register strobes.
// Assumes only aligned word offsets below NUM_REGS*4 map to registers.
module tt_decode
    import tt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel,
    output logic              hit,
    output logic              any_wr,
    output logic              wr_ctrl,
    output logic              wr_reload,
    output logic              wr_count,
    output logic              rd_ctrl
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;

    // Split the byte address into a word index and check alignment and range.
    always_comb begin
        word_idx = bus_addr[ADDR_W-1:2];
        hit      = (bus_addr[1:0] == 2'b00) && (int'(word_idx) < NUM_REGS);
        sel      = reg_sel_e'(word_idx[1:0]);
    end

    // Build per-register access strobes.
    always_comb begin
        any_wr    = bus_valid && bus_write;
        wr_ctrl   = any_wr && hit && (sel == SEL_CTRL);
        wr_reload = any_wr && hit && (sel == SEL_RELOAD);
        wr_count  = any_wr && hit && (sel == SEL_COUNT);
        rd_ctrl   = bus_valid && !bus_write && hit && (sel == SEL_CTRL);
    end
endmodule

// File: rtl/tt_tick_sel.sv
// Tick source selector: picks every core clock or the external reference strobe.
// Assumes ref_strobe is already synchronous to clk.
module tt_tick_sel (
    input  logic clk_src,
    input  logic ref_strobe,
    output logic tick
);
    // Choose the tick source.
    always_comb begin
        tick = clk_src ? 1'b1 : ref_strobe;
    end
endmodule

// File: rtl/tt_counter.sv
// Down counter with reload-after-rest, forced clear and halt on zero reload.
// Assumes at most one of arm/zap is set per cycle and that adv is low in write cycles.
module tt_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             arm,
    input  logic             zap,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             halted,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic reload_zero;

    // Flag a zero reload and an expiry (a decrement that lands on zero).
    always_comb begin
        reload_zero = (reload == ZERO);
        expire      = adv && (count == ONE);
    end

    // Update the count and the halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= ZERO;
            halted <= 1'b0;
        end else if (zap) begin
            count  <= ZERO;
            halted <= halted || reload_zero;
        end else if (arm) begin
            count  <= ZERO;
            halted <= 1'b0;
        end else if (adv) begin
            if (count == ZERO) begin
                if (reload_zero) begin
                    halted <= 1'b1;
                end else begin
                    count <= reload;
                end
            end else begin
                count <= count - ONE;
                if ((count == ONE) && reload_zero) begin
                    halted <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tt_regs.sv
// Register file: control bits, reload value, expiry flag, interrupt pulse and read mux.
// Assumes the decoder provides mutually exclusive write strobes.
module tt_regs
    import tt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int CALIB = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata,
    input  reg_sel_e          sel,
    input  logic              hit,
    input  logic              wr_ctrl,
    input  logic              wr_reload,
    input  logic              wr_count,
    input  logic              rd_ctrl,
    input  logic              expire,
    input  logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              flag,
    output logic              arm,
    output logic              irq,
    output logic [DATA_W-1:0] rdata
);
    ctrl_t wr_ctrl_val;

    // Pick the writable control bits from the write data, and detect an enable rise.
    always_comb begin
        wr_ctrl_val = ctrl_t'(wdata[CTRL_BITS-1:0]);
        arm         = wr_ctrl && wr_ctrl_val.run_en && !ctrl.run_en;
    end

    // Hold the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= wr_ctrl_val;
        end
    end

    // Hold the 24-bit reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (wr_reload) begin
            reload <= wdata[CNT_W-1:0];
        end
    end

    // Sticky expiry flag: an expiry sets it, a control read or count write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (wr_count || rd_ctrl) begin
            flag <= 1'b0;
        end
    end

    // Registered one-cycle interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= expire && ctrl.irq_en;
        end
    end

    // Read data mux; undefined addresses read zero.
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (sel)
                SEL_CTRL: begin
                    rdata[CTRL_BITS-1:0] = ctrl;
                    rdata[FLAG_BIT]      = flag;
                end
                SEL_RELOAD: rdata[CNT_W-1:0] = reload;
                SEL_COUNT:  rdata[CNT_W-1:0] = count;
                SEL_CALIB:  rdata = DATA_W'(CALIB);
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tick_timer.sv
// Top level of the periodic tick timer: decoder, tick select, registers and counter.
// Assumes a single-cycle register access port and an active-low synchronous reset.
module tick_timer
    import tt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 24,
    parameter int CALIB  = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_strobe,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_pulse
);
    reg_sel_e         sel;
    logic             hit, any_wr, wr_ctrl, wr_reload, wr_count, rd_ctrl;
    logic             tick, adv, arm, expire, halted, flag;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload, count;

    tt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .sel       (sel),
        .hit       (hit),
        .any_wr    (any_wr),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .wr_count  (wr_count),
        .rd_ctrl   (rd_ctrl)
    );

    tt_tick_sel u_tsel (
        .clk_src    (ctrl.clk_src),
        .ref_strobe (ref_strobe),
        .tick       (tick)
    );

    // Advance only when enabled, not halted, ticking, and no write is accepted.
    always_comb begin
        adv = ctrl.run_en && !halted && tick && !any_wr;
    end

    tt_regs #(.CNT_W(CNT_W), .CALIB(CALIB)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata     (bus_wdata),
        .sel       (sel),
        .hit       (hit),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .wr_count  (wr_count),
        .rd_ctrl   (rd_ctrl),
        .expire    (expire),
        .count     (count),
        .ctrl      (ctrl),
        .reload    (reload),
        .flag      (flag),
        .arm       (arm),
        .irq       (irq_pulse),
        .rdata     (bus_rdata)
    );

    tt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .arm    (arm),
        .zap    (wr_count),
        .reload (reload),
        .count  (count),
        .halted (halted),
        .expire (expire)
    );
endmodule

// File: rtl/tick_timer_chk.sv
// Property checker for the tick timer, bound to every instance of the top.
module tick_timer_chk #(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq_pulse,
    input logic              run_en,
    input logic              flag,
    input logic              halted,
    input logic              adv,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  reload
);
    logic wr;
    always_comb wr = bus_valid && bus_write;

    // R7: the pulse lasts one cycle and is backed by the flag
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> flag);

    // R9: no movement while disabled
    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr) |=> $stable(count));

    // R10: a current-value write clears count and flag
    assert_cvr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(8)) |=> (count == '0 && !flag));

    // R3: the reload register keeps the low 24 bits
    assert_reload_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(4)) |=> (reload == $past(bus_wdata[CNT_W-1:0])));

    // R5: a tick at zero loads the reload value
    assert_rest_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && count == '0 && reload != '0) |=> (count == $past(reload)));

    // R12: a halted counter does not move without a write
    assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !wr) |=> $stable(count));
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_pulse (irq_pulse),
    .run_en    (ctrl.run_en),
    .flag      (flag),
    .halted    (halted),
    .adv       (adv),
    .count     (count),
    .reload    (reload)
);

// File: tb/tick_timer_test.sv
// Scoreboard bench: read tasks queue expected and observed words; a monitor compares them.
module tick_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;
    localparam int A_CTRL = 'h0, A_RLD = 'h4, A_CNT = 'h8, A_CAL = 'hC, A_BAD = 'h10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_strobe = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_pulse;

    int total = 0;
    int bad   = 0;
    int irq_cnt = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    tick_timer #(.ADDR_W(ADDR_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_strobe (ref_strobe),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_pulse  (irq_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count interrupt pulses away from the active edge.
    always @(negedge clk) if (rst_n && irq_pulse) irq_cnt++;

    // Monitor: compare observed reads against expected ones.
    always @(posedge clk) begin
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            automatic logic [31:0] a = act_q.pop_front();
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s: actual=0x%08h expected=0x%08h", t, a, e);
            end
        end
    end

    task automatic check(input int act, input int exp, input string t);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input int a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string t);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ADDR_W'(a);
        #1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        act_q.push_back(bus_rdata);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic tick(input int n);
        ref_strobe = 1'b1;
        repeat (n) @(negedge clk);
        ref_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R11: reset values and calibration
        rd(A_CTRL, 32'h0, "R1 ctrl after reset");
        rd(A_RLD, 32'h0, "R1 reload after reset");
        rd(A_CNT, 32'h0, "R1 count after reset");
        rd(A_CAL, 32'd10000, "R11 calibration");
        // R3: 24-bit reload
        wr(A_RLD, 32'hFF00_0005);
        rd(A_RLD, 32'h5, "R3 reload masked");
        // R2: only low control bits stick
        wr(A_CTRL, 32'hFFFF_FFF3);
        rd(A_CTRL, 32'h3, "R2 control writable bits");
        rd(A_CNT, 32'h0, "R4 count zeroed on enable");
        tick(1);
        rd(A_CNT, 32'h5, "R4 reload after one tick");
        tick(3);
        rd(A_CNT, 32'h2, "R6 strobe ticks counted");
        idle(5);
        rd(A_CNT, 32'h2, "R6 no tick without strobe");
        tick(2);
        rd(A_CNT, 32'h0, "R5 rests at zero");
        rd(A_CTRL, 32'h0001_0003, "R8 flag in bit 16");
        rd(A_CTRL, 32'h3, "R8 flag cleared by read");
        check(irq_cnt, 1, "R7 one pulse on expiry");
        tick(1);
        rd(A_CNT, 32'h5, "R5 reload after rest");
        // R9: freeze
        tick(2);
        wr(A_CTRL, 32'h2);
        tick(4);
        rd(A_CNT, 32'h3, "R9 frozen while disabled");
        wr(A_CTRL, 32'h3);
        rd(A_CNT, 32'h0, "R4 re-enable zeroes count");
        tick(1);
        rd(A_CNT, 32'h5, "R4 reload after re-enable");
        // R10: current-value write
        tick(4);
        wr(A_CNT, 32'h123);
        rd(A_CNT, 32'h0, "R10 write zeroes count");
        rd(A_CTRL, 32'h3, "R10 no flag from forced zero");
        check(irq_cnt, 1, "R10 no pulse from forced zero");
        tick(1);
        rd(A_CNT, 32'h5, "R10 reload on next tick");
        tick(5);
        wr(A_CNT, 32'h0);
        rd(A_CTRL, 32'h3, "R10 write clears flag");
        check(irq_cnt, 2, "R7 second pulse");
        // R7: interrupt enable gates the pulse only
        tick(1);
        wr(A_CTRL, 32'h1);
        tick(5);
        rd(A_CTRL, 32'h0001_0001, "R7 flag without irq enable");
        check(irq_cnt, 2, "R7 no pulse when irq disabled");
        // R12: zero reload halts
        tick(1);
        tick(2);
        wr(A_RLD, 32'h0);
        tick(3);
        rd(A_CTRL, 32'h0001_0001, "R12 enable kept on halt");
        tick(3);
        rd(A_CNT, 32'h0, "R12 halted at zero");
        wr(A_RLD, 32'h2);
        tick(2);
        rd(A_CNT, 32'h0, "R12 stays halted after reload write");
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h1);
        tick(1);
        rd(A_CNT, 32'h2, "R12 restart on enable rise");
        // R6: core clock source
        wr(A_CTRL, 32'h4);
        wr(A_RLD, 32'h9);
        wr(A_CTRL, 32'h5);
        idle(3);
        rd(A_CNT, 32'h7, "R6 every clock ticks");
        wr(A_CTRL, 32'h0);
        rd(A_CNT, 32'h6, "R9 write cycle holds count");
        // R13 / R11: undefined and read-only addresses
        wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_BAD, 32'h0, "R13 undefined reads zero");
        rd(A_CTRL, 32'h0, "R13 control untouched");
        rd(A_RLD, 32'h9, "R13 reload untouched");
        rd(2, 32'h0, "R13 unaligned reads zero");
        wr(A_CAL, 32'h0);
        rd(A_CAL, 32'd10000, "R11 calibration read-only");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule